// File: doc/BRIEF.md
# Dual-Modulus Swallow Divider

This block is the feedback divider of a frequency synthesizer that uses an external two-modulus prescaler. The prescaler divides the oscillator by either P+1 or P. Each of its output pulses arrives here as a one-clock enable. Two down counters track the division. A main counter of 10 bits holds the total number of prescaler pulses per division cycle, N. A swallow counter of 7 bits holds how many of those pulses use the larger modulus, A. The block drives the modulus select back to the prescaler, so the oscillator is divided by N·P + A over one full cycle. At the end of every cycle the block emits a one-clock comparison pulse for the phase detector.

Software writes the N and A values into a holding register at any time. The counters copy that register only at a cycle boundary, so a running cycle is never disturbed. A write whose N is below the legal minimum is dropped. A cycle loaded with A greater than N cannot reach the P modulus, so the block keeps the large modulus for the whole cycle and latches a sticky error flag. The flag clears only on reset.

Top module: `swdiv_top`

## Requirements
- R1: After reset the holding register holds N=10 and A=3, the counters are loaded with those values, `fv_pulse` is 0, `err_sticky` is 0 and `mod_hi` is 1.
- R2: A clock on which `pre_en` is 0 changes neither counter. The clock after it has `fv_pulse` at 0 and `mod_hi` unchanged.
- R3: The clock edge that takes the N-th `pre_en` pulse of a cycle reloads both counters from the holding register. `fv_pulse` is 1 for exactly the one clock that follows that edge.
- R4: `mod_hi` (1 = divide by P+1, 0 = divide by P) is 1 while the first A pulses of a cycle are counted and 0 for the remaining N−A pulses.
- R5: With A=0, `mod_hi` stays 0 for the whole cycle.
- R6: If a reload brings in A>N, `mod_hi` stays 1 for all N pulses of that cycle. `err_sticky` becomes 1 from the clock after that reload and stays 1 until reset.
- R7: A write through `cfg_wr` updates only the holding register. The values take effect at the first cycle boundary after the write. The cycle in progress keeps its old N and A.
- R8: A write with `cfg_n` below 3 is ignored, and the holding register keeps its previous contents.
- R9: With a prescaler that follows `mod_hi`, the number of clocks between two successive `fv_pulse` assertions is N·P + A when A≤N, and N·(P+1) when A>N.
- R10: A=N is legal. `mod_hi` stays 1 for the entire cycle and `err_sticky` is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| pre_en | input | 1 | One-clock enable per prescaler output pulse |
| cfg_wr | input | 1 | Write strobe for the holding register |
| cfg_n | input | 10 | Main count N to write (3..1023) |
| cfg_a | input | 7 | Swallow count A to write (0..127) |
| mod_hi | output | 1 | Modulus select: 1 = P+1, 0 = P |
| fv_pulse | output | 1 | One-clock pulse at the end of each division cycle |
| err_sticky | output | 1 | Set when a cycle was loaded with A greater than N |

## Verification
The hardest condition to reach is a write that lands in the middle of a running cycle. Its effect must appear exactly one boundary later, never earlier. The bench therefore issues writes at a chosen clock offset after an `fv_pulse` and measures both the cycle that is still running and the cycle that follows it. A behavioural prescaler closes the loop by choosing each pulse's length from `mod_hi`. This makes modulus errors show up as wrong cycle lengths, and a per-clock reference model catches any single-cycle slip.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  // Default geometry of the divider
  localparam int unsigned SWD_NW    = 10;
  localparam int unsigned SWD_AW    = 7;
  localparam int unsigned SWD_N_MIN = 3;
  localparam int unsigned SWD_N_DEF = 10;
  localparam int unsigned SWD_A_DEF = 3;

  // Modulus selection presented to the prescaler
  typedef enum logic {
    MOD_LOW  = 1'b0,   // divide by P
    MOD_HIGH = 1'b1    // divide by P+1
  } mod_sel_e;

endpackage

// File: rtl/swdiv_prog_reg.sv
// Holding register for N and A; rejects writes with N below the minimum.
module swdiv_prog_reg #(
  parameter int unsigned NW    = swdiv_pkg::SWD_NW,
  parameter int unsigned AW    = swdiv_pkg::SWD_AW,
  parameter int unsigned N_MIN = swdiv_pkg::SWD_N_MIN,
  parameter int unsigned N_DEF = swdiv_pkg::SWD_N_DEF,
  parameter int unsigned A_DEF = swdiv_pkg::SWD_A_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [NW-1:0] wr_n,
  input  logic [AW-1:0] wr_a,
  output logic [NW-1:0] hold_n,
  output logic [AW-1:0] hold_a
);

  logic [NW-1:0] n_q, n_d;
  logic [AW-1:0] a_q, a_d;
  logic          accept;

  // A write is taken only when its N value is legal
  assign accept = wr_en && (wr_n >= NW'(N_MIN));

  always_comb begin
    n_d = n_q;
    a_d = a_q;
    if (accept) begin
      n_d = wr_n;
      a_d = wr_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= NW'(N_DEF);
      a_q <= AW'(A_DEF);
    end else if (accept) begin
      n_q <= n_d;
      a_q <= a_d;
    end
  end

  assign hold_n = n_q;
  assign hold_a = a_q;

endmodule

// File: rtl/swdiv_n_ctr.sv
// Main down counter: counts prescaler pulses, flags its last pulse.
module swdiv_n_ctr #(
  parameter int unsigned NW    = swdiv_pkg::SWD_NW,
  parameter int unsigned N_DEF = swdiv_pkg::SWD_N_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          reload,
  input  logic [NW-1:0] load_val,
  output logic          last
);

  logic [NW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = step || reload;

  always_comb begin
    cnt_d = cnt_q;
    if (reload) begin
      cnt_d = load_val;
    end else if (step) begin
      cnt_d = cnt_q - NW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= NW'(N_DEF);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // The pulse taken while the count is one ends the cycle
  assign last = (cnt_q == NW'(1));

endmodule

// File: rtl/swdiv_a_ctr.sv
// Swallow counter: large modulus while nonzero, saturates at zero.
module swdiv_a_ctr #(
  parameter int unsigned AW    = swdiv_pkg::SWD_AW,
  parameter int unsigned A_DEF = swdiv_pkg::SWD_A_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          reload,
  input  logic [AW-1:0] load_val,
  output swdiv_pkg::mod_sel_e mod_sel
);

  logic [AW-1:0] cnt_q, cnt_d;
  logic          nonzero;
  logic          cnt_en;

  assign nonzero = (cnt_q != '0);
  assign cnt_en  = reload || (step && nonzero);

  always_comb begin
    cnt_d = cnt_q;
    if (reload) begin
      cnt_d = load_val;
    end else if (step && nonzero) begin
      cnt_d = cnt_q - AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= AW'(A_DEF);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign mod_sel = nonzero ? swdiv_pkg::MOD_HIGH : swdiv_pkg::MOD_LOW;

endmodule

// File: rtl/swdiv_top.sv
module swdiv_top #(
  parameter int unsigned NW    = swdiv_pkg::SWD_NW,
  parameter int unsigned AW    = swdiv_pkg::SWD_AW,
  parameter int unsigned N_MIN = swdiv_pkg::SWD_N_MIN,
  parameter int unsigned N_DEF = swdiv_pkg::SWD_N_DEF,
  parameter int unsigned A_DEF = swdiv_pkg::SWD_A_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_en,
  input  logic          cfg_wr,
  input  logic [NW-1:0] cfg_n,
  input  logic [AW-1:0] cfg_a,
  output logic          mod_hi,
  output logic          fv_pulse,
  output logic          err_sticky
);

  // Comparison width for the A > N test
  localparam int unsigned CW = (NW > AW) ? NW : AW;

  logic [NW-1:0]       hold_n;
  logic [AW-1:0]       hold_a;
  logic                n_last;
  logic                reload;
  logic                bad_load;
  swdiv_pkg::mod_sel_e mod_sel;

  logic fv_q, fv_d;
  logic err_q, err_d;

  swdiv_prog_reg #(
    .NW(NW), .AW(AW), .N_MIN(N_MIN), .N_DEF(N_DEF), .A_DEF(A_DEF)
  ) u_prog (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr),
    .wr_n   (cfg_n),
    .wr_a   (cfg_a),
    .hold_n (hold_n),
    .hold_a (hold_a)
  );

  assign reload = pre_en && n_last;

  swdiv_n_ctr #(.NW(NW), .N_DEF(N_DEF)) u_nctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (pre_en),
    .reload   (reload),
    .load_val (hold_n),
    .last     (n_last)
  );

  swdiv_a_ctr #(.AW(AW), .A_DEF(A_DEF)) u_actr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (pre_en),
    .reload   (reload),
    .load_val (hold_a),
    .mod_sel  (mod_sel)
  );

  assign bad_load = CW'(hold_a) > CW'(hold_n);

  always_comb begin
    fv_d  = reload;
    err_d = err_q || (reload && bad_load);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      fv_q  <= fv_d;
      err_q <= err_d;
    end
  end

  assign mod_hi     = (mod_sel == swdiv_pkg::MOD_HIGH);
  assign fv_pulse   = fv_q;
  assign err_sticky = err_q;

endmodule

// File: rtl/swdiv_chk.sv
module swdiv_chk (
  input logic clk,
  input logic rst_n,
  input logic pre_en,
  input logic mod_hi,
  input logic fv_pulse,
  input logic err_sticky
);

  // R3: the end-of-cycle pulse lasts one clock
  assert_fv_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fv_pulse |=> !fv_pulse);

  // R2: without a prescaler pulse nothing advances
  assert_idle_no_fv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_en |=> !fv_pulse);

  assert_idle_mod_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_en |=> $stable(mod_hi));

  // R4: the large modulus only returns at a cycle boundary
  assert_mod_rise_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_hi) |-> fv_pulse);

  // R6: the error flag never clears without reset
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  // R6: the flag may only rise at a cycle boundary
  assert_err_rise_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky) |-> fv_pulse);

endmodule

bind swdiv_top swdiv_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pre_en     (pre_en),
  .mod_hi     (mod_hi),
  .fv_pulse   (fv_pulse),
  .err_sticky (err_sticky)
);

// File: tb/sim_swdiv_top.sv
module sim_swdiv_top;

  localparam int CLK_PERIOD = 10;
  localparam int PSC        = 4;
  localparam int WDOG       = 150000;

  logic       clk;
  logic       rst_n;
  logic       pre_en;
  logic       cfg_wr;
  logic [9:0] cfg_n;
  logic [6:0] cfg_a;
  logic       mod_hi, fv_pulse, err_sticky;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  swdiv_top u0 (
    .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .cfg_wr(cfg_wr),
    .cfg_n(cfg_n), .cfg_a(cfg_a), .mod_hi(mod_hi), .fv_pulse(fv_pulse),
    .err_sticky(err_sticky)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int hn = 10, ha = 3, rn = 10, ra = 3;
  int rfv = 0, rerr = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      int nn, na;
      bit wr;
      wr = cfg_wr && (cfg_n >= 3);
      nn = cfg_n; na = cfg_a;
      rfv = 0;
      if (pre_en) begin
        if (rn == 1) begin
          rn = hn; ra = ha; rfv = 1;
          if (ha > hn) rerr = 1;
        end else begin
          rn--;
          if (ra > 0) ra--;
        end
      end
      if (wr) begin hn = nn; ha = na; end
    end
  end

  // Per-clock comparison and behavioural prescaler
  bit psc_on = 0;
  bit psc_run = 0;
  int pc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      check("R4", int'(mod_hi), (ra != 0) ? 1 : 0, "mod_hi vs model");
      check("R3", int'(fv_pulse), rfv, "fv_pulse vs model");
      check("R6", int'(err_sticky), rerr, "err_sticky vs model");
    end
    if (!psc_on) begin
      psc_run = 0;
      pre_en  = 1'b0;
    end else begin
      if (!psc_run || pre_en) pc = mod_hi ? PSC + 1 : PSC;
      psc_run = 1;
      pc--;
      pre_en = (pc == 0);
    end
  end

  task automatic write_cfg(input int n, input int a);
    cfg_n  = 10'(n);
    cfg_a  = 7'(a);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_fv();
    do @(negedge clk); while (!fv_pulse);
  endtask

  // Measure one cycle from an fv pulse; optional write at offset wr_at
  task automatic measure(input int wr_at, input int wn, input int wa,
                         output int period, output int high);
    int cnt;
    wait_fv();
    cnt = 0; high = 0;
    do begin
      high += int'(mod_hi);
      if (cnt == wr_at) begin
        write_cfg(wn, wa);
      end else begin
        @(negedge clk);
      end
      cnt++;
    end while (!fv_pulse);
    period = cnt;
  endtask

  task automatic run_case(input string req, input int n, input int a);
    int per, hi, expp, exph;
    expp = (a > n) ? n * (PSC + 1) : n * PSC + a;
    exph = (a > n) ? expp : a * (PSC + 1);
    measure(-1, 0, 0, per, hi);
    check(req, per, expp, "cycle length");
    check(req, hi, exph, "clocks at large modulus");
  endtask

  initial begin
    int per, hi;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_n = '0; cfg_a = '0; pre_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(mod_hi), 1, "reset mod_hi");
    check("R1", int'(fv_pulse), 0, "reset fv_pulse");
    check("R1", int'(err_sticky), 0, "reset err_sticky");
    rst_n = 1'b1;

    // R2: no prescaler pulses, nothing moves
    repeat (20) begin
      @(negedge clk);
      check("R2", int'(fv_pulse), 0, "idle fv_pulse");
      check("R2", int'(mod_hi), 1, "idle mod_hi");
    end

    // R9 / R4 with default values N=10 A=3
    psc_on = 1;
    wait_fv();
    run_case("R9", 10, 3);

    // R7: mid-cycle write leaves running cycle untouched
    measure(7, 20, 5, per, hi);
    check("R7", per, 10 * PSC + 3, "cycle with write in flight");
    run_case("R7", 20, 5);

    // R8: N below minimum is rejected
    write_cfg(2, 1);
    wait_fv();
    run_case("R8", 20, 5);

    // R5: A = 0
    write_cfg(3, 0);
    wait_fv();
    run_case("R5", 3, 0);

    // R10: A equals N
    write_cfg(6, 6);
    wait_fv();
    run_case("R10", 6, 6);
    check("R10", int'(err_sticky), 0, "no error when A equals N");

    // R6: A greater than N
    write_cfg(4, 9);
    wait_fv();
    check("R6", int'(err_sticky), 1, "error set at bad reload");
    run_case("R6", 4, 9);
    write_cfg(12, 7);
    wait_fv();
    run_case("R6", 12, 7);
    check("R6", int'(err_sticky), 1, "error remains after good values");

    // R9: extremes of the ranges
    write_cfg(1023, 127);
    wait_fv();
    run_case("R9", 1023, 127);
    write_cfg(3, 3);
    wait_fv();
    run_case("R9", 3, 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule